// File: doc/BRIEF.md
# Prioritized Two-Lamp Status Indicator

This block drives a green and a red status lamp for a fieldbus slave node. Both lamp outputs are active low and are meant for open-drain pads: a driven 0 lights a lamp wired to the supply, and a 1 leaves it dark. The block watches five conditions: supply presence, an overload-or-external-reset flag, an active-low peripheral fault pin, the health of the stored node address, and the communication watchdog. Each cycle it picks the most urgent of these and shows a fixed lamp pattern for it. A pattern can be steady, blinking, or alternating between the two lamps.

A free-running divider of the system clock makes the blink timebase, nominally 2.5 Hz with an even duty cycle. The divider is cleared only by the hard reset. The overload/reset flag never touches it, so the blink rhythm carries on through soft resets. The node address is held in two redundant copies. A copy pair that is zero, or a pair whose copies differ, counts as "no valid address".

The state is registered. A change at the inputs reaches the lamps after one clock edge.

Top module: `status_lamp_ctrl`

Internal states: `LS_DARK` (no supply), `LS_RUN` (normal), `LS_NOCOMM` (watchdog expired), `LS_NOADDR` (address invalid), `LS_PERIPH` (peripheral fault), `LS_HALT` (overload or external reset). On every clock edge the state register loads the highest-priority state whose condition holds. Any state can therefore move directly to any other state.

## Requirements
- R1: While `rst_n` is low, both `green_n` and `red_n` are 1.
- R2: If `supply_ok` is 0, both outputs are 1, whatever the other inputs are.
- R3: With supply present, no overload flag, `periph_fault_n` = 1, a valid address and `wdog_expired` = 0, the outputs are `green_n` = 0 and `red_n` = 1.
- R4: With supply present and `ovl_or_ext_rst` = 1 (priority 1), `green_n` = 1 and `red_n` blinks: 0 when the blink phase is 0, 1 when the phase is 1.
- R5: With supply present, no overload flag and `periph_fault_n` = 0 (priority 2), the lamps alternate: `green_n` equals the phase and `red_n` equals its inverse.
- R6: At priority 3 (address invalid, nothing higher), `green_n` equals the phase and `red_n` = 0.
- R7: The address counts as invalid when `addr_copy_a` differs from `addr_copy_b`, or when both copies are zero.
- R8: At priority 4 (valid address with `wdog_expired` = 1, nothing higher), `green_n` = 1 and `red_n` = 0.
- R9: The blink phase is 0 right after reset. It inverts after every HALF_CYC = CLK_HZ*500/BLINK_MILLIHZ clock edges. After k edges since reset release, the phase is (k / HALF_CYC) mod 2.
- R10: The overload/reset flag does not clear or pause the blink timebase. The phase keeps following R9 across any number of flag assertions.
- R11: The outputs reflect the inputs sampled at the most recent clock edge: the latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 5.333 MHz) |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| supply_ok | input | 1 | Supply present |
| ovl_or_ext_rst | input | 1 | Output overload or external reset in progress |
| periph_fault_n | input | 1 | Peripheral fault, active low |
| wdog_expired | input | 1 | Communication watchdog has expired |
| addr_copy_a | input | ADDR_W | First stored copy of the node address |
| addr_copy_b | input | ADDR_W | Second stored copy of the node address |
| green_n | output | 1 | Green lamp drive, 0 = lit |
| red_n | output | 1 | Red lamp drive, 0 = lit |

## Verification
A wrong state shows up within one clock edge as a lamp pair that does not match the priority table. A priority inversion, for example, would show a steady red where an alternating pattern belongs. A fault in the blink divider or the phase register is different: it only shows when the phase is expected to change, so it can stay hidden for up to HALF_CYC edges. For that reason the bench predicts the phase on every cycle from the edge count since reset, and it runs long enough to cover many phase inversions while the overload flag is toggled.

// File: rtl/status_lamp_pkg.sv
`timescale 1ns/1ps
package status_lamp_pkg;
    typedef enum logic [2:0] {
        LS_DARK   = 3'd0,
        LS_RUN    = 3'd1,
        LS_NOCOMM = 3'd2,
        LS_NOADDR = 3'd3,
        LS_PERIPH = 3'd4,
        LS_HALT   = 3'd5
    } lamp_state_t;
endpackage

// File: rtl/blink_timebase.sv
`timescale 1ns/1ps
module blink_timebase #(
    parameter int unsigned HALF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int unsigned CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/addr_health.sv
`timescale 1ns/1ps
module addr_health #(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] copy_a,
    input  logic [ADDR_W-1:0] copy_b,
    output logic              addr_ok
);
    logic agree;
    logic nonzero;

    always_comb begin
        agree   = (copy_a == copy_b);
        nonzero = |copy_a;
        addr_ok = agree && nonzero;
    end
endmodule

// File: rtl/lamp_fsm.sv
`timescale 1ns/1ps
module lamp_fsm
    import status_lamp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic halt_req,
    input  logic periph_fault_n,
    input  logic addr_ok,
    input  logic wdog_expired,
    input  logic phase,
    output logic green_n,
    output logic red_n
);
    lamp_state_t state_q, state_d;

    always_comb begin
        if (!supply_ok)          state_d = LS_DARK;
        else if (halt_req)       state_d = LS_HALT;
        else if (!periph_fault_n) state_d = LS_PERIPH;
        else if (!addr_ok)       state_d = LS_NOADDR;
        else if (wdog_expired)   state_d = LS_NOCOMM;
        else                     state_d = LS_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LS_DARK;
        else        state_q <= state_d;
    end

    always_comb begin
        green_n = 1'b1;
        red_n   = 1'b1;
        unique case (state_q)
            LS_DARK:   begin green_n = 1'b1;   red_n = 1'b1;   end
            LS_RUN:    begin green_n = 1'b0;   red_n = 1'b1;   end
            LS_NOCOMM: begin green_n = 1'b1;   red_n = 1'b0;   end
            LS_NOADDR: begin green_n = phase;  red_n = 1'b0;   end
            LS_PERIPH: begin green_n = phase;  red_n = ~phase; end
            LS_HALT:   begin green_n = 1'b1;   red_n = phase;  end
            default:   begin green_n = 1'b1;   red_n = 1'b1;   end
        endcase
    end
endmodule

// File: rtl/status_lamp_ctrl.sv
`timescale 1ns/1ps
module status_lamp_ctrl #(
    parameter int unsigned CLK_HZ        = 5333333,
    parameter int unsigned BLINK_MILLIHZ = 2500,
    parameter int unsigned ADDR_W        = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              ovl_or_ext_rst,
    input  logic              periph_fault_n,
    input  logic              wdog_expired,
    input  logic [ADDR_W-1:0] addr_copy_a,
    input  logic [ADDR_W-1:0] addr_copy_b,
    output logic              green_n,
    output logic              red_n
);
    localparam longint HALF_L = (longint'(CLK_HZ) * 500) / longint'(BLINK_MILLIHZ);
    localparam int unsigned HALF_CYC = (HALF_L < 1) ? 1 : int'(HALF_L);

    logic phase;
    logic addr_ok;

    blink_timebase #(.HALF_CYC(HALF_CYC)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    addr_health #(.ADDR_W(ADDR_W)) u_addr (
        .copy_a  (addr_copy_a),
        .copy_b  (addr_copy_b),
        .addr_ok (addr_ok)
    );

    lamp_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok      (supply_ok),
        .halt_req       (ovl_or_ext_rst),
        .periph_fault_n (periph_fault_n),
        .addr_ok        (addr_ok),
        .wdog_expired   (wdog_expired),
        .phase          (phase),
        .green_n        (green_n),
        .red_n          (red_n)
    );
endmodule

// File: rtl/status_lamp_chk.sv
`timescale 1ns/1ps
module status_lamp_chk #(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic              ovl_or_ext_rst,
    input logic              periph_fault_n,
    input logic              wdog_expired,
    input logic [ADDR_W-1:0] addr_copy_a,
    input logic [ADDR_W-1:0] addr_copy_b,
    input logic              green_n,
    input logic              red_n
);
    logic valid_addr;
    assign valid_addr = (addr_copy_a == addr_copy_b) && (addr_copy_a != '0);

    always_comb begin
        if (!rst_n) a_r1_dark_in_reset: assert (green_n && red_n);
    end

    a_r2_no_supply_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (green_n && red_n));

    a_r4_halt_green_off: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && ovl_or_ext_rst) |=> green_n);

    a_r5_periph_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !ovl_or_ext_rst && !periph_fault_n) |=> (green_n != red_n));

    a_r6_noaddr_red_on: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !ovl_or_ext_rst && periph_fault_n && !valid_addr) |=> !red_n);

    a_r8_nocomm_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !ovl_or_ext_rst && periph_fault_n && valid_addr && wdog_expired)
        |=> (green_n && !red_n));

    a_r3_run_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !ovl_or_ext_rst && periph_fault_n && valid_addr && !wdog_expired)
        |=> (!green_n && red_n));
endmodule

bind status_lamp_ctrl status_lamp_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok      (supply_ok),
    .ovl_or_ext_rst (ovl_or_ext_rst),
    .periph_fault_n (periph_fault_n),
    .wdog_expired   (wdog_expired),
    .addr_copy_a    (addr_copy_a),
    .addr_copy_b    (addr_copy_b),
    .green_n        (green_n),
    .red_n          (red_n)
);

// File: tb/status_lamp_ctrl_tb_top.sv
`timescale 1ns/1ps
module status_lamp_ctrl_tb_top;
    localparam int unsigned CLK_HZ   = 40;
    localparam int unsigned BLINK_MH = 2500;
    localparam int unsigned ADDR_W   = 6;
    localparam int unsigned HALF     = CLK_HZ * 500 / BLINK_MH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic ovl = 1'b0;
    logic pf_n = 1'b1;
    logic wd = 1'b0;
    logic [ADDR_W-1:0] a = '0;
    logic [ADDR_W-1:0] b = '0;
    logic green_n, red_n;

    int checks = 0;
    int errors = 0;
    int edges = 0;

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    status_lamp_ctrl #(.CLK_HZ(CLK_HZ), .BLINK_MILLIHZ(BLINK_MH), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ovl_or_ext_rst(ovl),
        .periph_fault_n(pf_n), .wdog_expired(wd), .addr_copy_a(a), .addr_copy_b(b),
        .green_n(green_n), .red_n(red_n)
    );

    function automatic logic model_phase(int k);
        return logic'((k / HALF) % 2);
    endfunction

    function automatic void model(input logic s, input logic o, input logic p,
                                  input logic w, input logic [ADDR_W-1:0] x,
                                  input logic [ADDR_W-1:0] y, input logic ph,
                                  output logic g, output logic r, output string tag);
        logic bad;
        bad = (x != y) || (x == '0);
        if (!s)      begin g = 1'b1; r = 1'b1; tag = "R2"; end
        else if (o)  begin g = 1'b1; r = ph;   tag = "R4/R10"; end
        else if (!p) begin g = ph;   r = ~ph;  tag = "R5/R9"; end
        else if (bad) begin g = ph;  r = 1'b0; tag = (x != y) ? "R7" : "R6"; end
        else if (w)  begin g = 1'b1; r = 1'b0; tag = "R8"; end
        else         begin g = 1'b0; r = 1'b1; tag = "R3"; end
    endfunction

    task automatic check_now(input string extra);
        logic eg, er;
        string tag;
        model(supply_ok, ovl, pf_n, wd, a, b, model_phase(edges), eg, er, tag);
        checks++;
        if (green_n !== eg || red_n !== er) begin
            errors++;
            $display("FAIL %s %s R11: got g=%b r=%b expected g=%b r=%b (edge %0d)",
                     tag, extra, green_n, red_n, eg, er, edges);
        end
    endtask

    task automatic step_check(input string extra);
        @(posedge clk);
        @(negedge clk);
        check_now(extra);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        supply_ok = 1'b1; a = 6'd9; b = 6'd9;
        repeat (3) @(negedge clk);
        checks++;
        if (green_n !== 1'b1 || red_n !== 1'b1) begin
            errors++;
            $display("FAIL R1: got g=%b r=%b expected g=1 r=1", green_n, red_n);
        end
        rst_n = 1'b1;
        // R3 normal running
        step_check("run");
        // R2 supply loss overrides fault and overload
        supply_ok = 1'b0; ovl = 1'b1; pf_n = 1'b0;
        step_check("nosupply");
        supply_ok = 1'b1; ovl = 1'b0; pf_n = 1'b1;
        // R7 mismatched nonzero copies treated as zero address
        a = 6'd5; b = 6'd21;
        for (int i = 0; i < 2 * HALF + 2; i++) step_check("mismatch");
        // R6 both copies zero
        a = '0; b = '0;
        for (int i = 0; i < 2 * HALF; i++) step_check("zero");
        // R8 watchdog with valid address
        a = 6'd33; b = 6'd33; wd = 1'b1;
        step_check("wdog");
        // R5 alternating over two full blink periods
        pf_n = 1'b0;
        for (int i = 0; i < 4 * HALF; i++) step_check("periph");
        // R4 / R10 overload pulses do not disturb blink timebase
        for (int i = 0; i < 6 * HALF; i++) begin
            ovl = (i % 3) != 0;
            step_check("halt");
        end
        ovl = 1'b0;
        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int hold;
            supply_ok = ($urandom % 8) != 0;
            ovl       = ($urandom % 5) == 0;
            pf_n      = ($urandom % 4) != 0;
            wd        = ($urandom % 3) == 0;
            a         = (($urandom % 6) == 0) ? '0 : ADDR_W'($urandom);
            b         = (($urandom % 4) == 0) ? ADDR_W'($urandom) : a;
            hold      = 1 + ($urandom % 5);
            for (int h = 0; h < hold; h++) step_check("random");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule